// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Exception-Flag Updates

This block performs 64-bit integer addition, subtraction, negation and signed comparison, and works out how the fixed-point exception flags change: the sticky summary-overflow bit, the carry pair (carry plus its 32-bit shadow) and the overflow pair (overflow plus its 32-bit shadow). It also produces the four-bit condition field for the first condition slot. All outputs are registered once, so results appear one clock after the operation is presented.

Every flag has its own write-enable. A downstream scoreboard can therefore track each flag as a separate architectural register and ignore an operation that does not touch a given flag. The 32-bit shadow flags are always taken from the low 32-bit slice, whatever the mode. A mode bit selects whether the main flags and the condition field are taken at 32-bit or 64-bit width. The full 64-bit result is produced in both modes.

Top module: `xer_addsub_unit`

## Requirements
- R1: Opcode codes are ADD=0, ADDC=1, ADDE=2, SUBF=3, SUBFC=4, SUBFE=5, NEG=6, CMP=7, ADDEX=8. The results are, in order: A+B, A+B, A+B+CA, B+~A+1, B+~A+1, B+~A+CA, ~A+1 and A+B+CA for ADDEX, all modulo 2^64. Each of these opcodes asserts the result write-enable. All outputs appear one clock after in_valid_i.
- R2: ADDC, ADDE, SUBFC, SUBFE and ADDEX assert both carry write-enables. ca_o[1] is the carry out of bit 63 in 64-bit mode and the carry out of bit 31 in 32-bit mode. ca_o[0] is always the carry out of bit 31.
- R3: ADD, SUBF and NEG never assert either carry write-enable.
- R4: With oe_i=1, the opcodes ADD through NEG assert both overflow write-enables. ov_o[1] is signed overflow at the active width, and ov_o[0] is signed overflow of the low 32-bit slice. With oe_i=0 these opcodes write no overflow flag.
- R5: ADDEX ignores oe_i. With cy_sel_i=0 it writes ov_o[1] with the active-width carry out and ov_o[0] with the carry out of bit 31. With cy_sel_i=1 it writes neither overflow flag nor SO.
- R6: so_we_o is asserted exactly when the overflow flags are written. so_o is then so_i OR ov_o[1], so SO is never cleared.
- R7: For every opcode except CMP and the unused codes, rc_i=1 asserts cr0_we_o. cr0_o holds {LT, GT, EQ, SO}: LT, GT and EQ come from the signed result at the active width, and bit 0 is the SO value after the update.
- R8: CMP always asserts cr0_we_o and holds SO, CA, OV and the result write-enable low. cr0_o is then {A<B, A>B, A==B, so_i}, with A and B compared as signed values at the active width.
- R9: In 32-bit mode (mode64_i=0) the upper 32 result bits are still the full 64-bit sum. The flags and the condition field depend only on bits 31..0 and the carry out of bit 31.
- R10: Codes 9 to 15 assert no write-enable. When in_valid_i is low, no write-enable is asserted one clock later and out_valid_o is low.
- R11: While rst is high, out_valid_o and every write-enable are cleared at each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operation present |
| op_i | input | 4 | Opcode (R1 codes) |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B, register or immediate |
| so_i | input | 1 | Current summary overflow |
| ca_i | input | 1 | Current carry |
| oe_i | input | 1 | Overflow-record enable |
| rc_i | input | 1 | Condition-record enable |
| mode64_i | input | 1 | 1 = 64-bit flags, 0 = 32-bit flags |
| cy_sel_i | input | 1 | ADDEX carry-select field |
| out_valid_o | output | 1 | Registered copy of in_valid_i |
| result_o | output | 64 | Sum |
| res_we_o | output | 1 | Result write-enable |
| cr0_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr0_we_o | output | 1 | Condition field write-enable |
| so_o | output | 1 | New summary overflow |
| so_we_o | output | 1 | SO write-enable |
| ca_o | output | 2 | {CA, CA32} |
| ca_we_o | output | 1 | CA write-enable |
| ca32_we_o | output | 1 | CA32 write-enable |
| ov_o | output | 2 | {OV, OV32} |
| ov_we_o | output | 1 | OV write-enable |
| ov32_we_o | output | 1 | OV32 write-enable |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath and a 32-bit shadow slice. These values put the two carry positions 32 bits apart, so an operand such as 0x00000000_FFFFFFFF shows a carry at bit 31 with no carry at bit 63. The same spacing lets signed overflow at one width be checked against its absence at the other. With these widths, the boundary operands (zero, all ones, the most-negative value of each width and its neighbours) can be given to every opcode in both modes.

// File: rtl/xau_pkg.sv
package xau_pkg;

    typedef enum logic [3:0] {
        XOP_ADD   = 4'd0,
        XOP_ADDC  = 4'd1,
        XOP_ADDE  = 4'd2,
        XOP_SUBF  = 4'd3,
        XOP_SUBFC = 4'd4,
        XOP_SUBFE = 4'd5,
        XOP_NEG   = 4'd6,
        XOP_CMP   = 4'd7,
        XOP_ADDEX = 4'd8
    } xop_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_CA   = 2'd2
    } cin_sel_e;

    typedef struct packed {
        logic     known;
        logic     inv_a;
        logic     zero_b;
        cin_sel_e cin_sel;
        logic     wr_res;
        logic     wr_ca;
        logic     ov_by_oe;
        logic     ov_is_carry;
        logic     is_cmp;
    } xctl_t;

    typedef struct packed {
        logic       res_we;
        logic       cr0_we;
        logic [3:0] cr0;
        logic       so_we;
        logic       so;
        logic       ca_we;
        logic       ca32_we;
        logic       ca;
        logic       ca32;
        logic       ov_we;
        logic       ov32_we;
        logic       ov;
        logic       ov32;
    } xflags_t;

    function automatic xctl_t xau_decode(input logic [3:0] code, input logic cy_sel);
        xctl_t c;
        c = '0;
        c.cin_sel = CIN_ZERO;
        case (code)
            XOP_ADD: begin
                c.known = 1'b1; c.wr_res = 1'b1; c.ov_by_oe = 1'b1;
            end
            XOP_ADDC: begin
                c.known = 1'b1; c.wr_res = 1'b1; c.ov_by_oe = 1'b1; c.wr_ca = 1'b1;
            end
            XOP_ADDE: begin
                c.known = 1'b1; c.wr_res = 1'b1; c.ov_by_oe = 1'b1; c.wr_ca = 1'b1;
                c.cin_sel = CIN_CA;
            end
            XOP_SUBF: begin
                c.known = 1'b1; c.wr_res = 1'b1; c.ov_by_oe = 1'b1;
                c.inv_a = 1'b1; c.cin_sel = CIN_ONE;
            end
            XOP_SUBFC: begin
                c.known = 1'b1; c.wr_res = 1'b1; c.ov_by_oe = 1'b1; c.wr_ca = 1'b1;
                c.inv_a = 1'b1; c.cin_sel = CIN_ONE;
            end
            XOP_SUBFE: begin
                c.known = 1'b1; c.wr_res = 1'b1; c.ov_by_oe = 1'b1; c.wr_ca = 1'b1;
                c.inv_a = 1'b1; c.cin_sel = CIN_CA;
            end
            XOP_NEG: begin
                c.known = 1'b1; c.wr_res = 1'b1; c.ov_by_oe = 1'b1;
                c.inv_a = 1'b1; c.zero_b = 1'b1; c.cin_sel = CIN_ONE;
            end
            XOP_CMP: begin
                c.known = 1'b1; c.is_cmp = 1'b1;
            end
            XOP_ADDEX: begin
                c.known = 1'b1; c.wr_res = 1'b1; c.wr_ca = 1'b1;
                c.cin_sel = CIN_CA; c.ov_is_carry = ~cy_sel;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    // Condition field layout: {less, greater, equal, summary overflow}
    function automatic logic [3:0] xau_cr_pack(input logic lt, input logic gt,
                                               input logic eq, input logic so);
        return {lt, gt, eq, so};
    endfunction

endpackage

// File: rtl/xau_operand.sv
module xau_operand
    import xau_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            inv_a,
    input  logic            zero_b,
    input  cin_sel_e        cin_sel,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            ca_in,
    output logic [XLEN-1:0] x,
    output logic [XLEN-1:0] y,
    output logic            cin
);
    always_comb begin
        x = inv_a ? ~a : a;
        y = zero_b ? '0 : b;
        case (cin_sel)
            CIN_ONE: cin = 1'b1;
            CIN_CA:  cin = ca_in;
            default: cin = 1'b0;
        endcase
    end
endmodule

// File: rtl/xau_adder.sv
module xau_adder #(
    parameter int XLEN  = 64,
    parameter int LOW_W = 32
) (
    input  logic [XLEN-1:0] x,
    input  logic [XLEN-1:0] y,
    input  logic            cin,
    output logic [XLEN-1:0] sum,
    output logic            c_low,
    output logic            c_top,
    output logic            sov_low,
    output logic            sov_top
);
    localparam int HI_W = XLEN - LOW_W;

    logic [LOW_W:0] lo_seg;
    logic [HI_W:0]  hi_seg;
    logic           into_low_msb;
    logic           into_top_msb;

    // Two segments: the boundary carry is a real wire, not a reconstruction.
    always_comb begin
        lo_seg = {1'b0, x[LOW_W-1:0]} + {1'b0, y[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
        hi_seg = {1'b0, x[XLEN-1:LOW_W]} + {1'b0, y[XLEN-1:LOW_W]}
               + {{HI_W{1'b0}}, lo_seg[LOW_W]};
        sum    = {hi_seg[HI_W-1:0], lo_seg[LOW_W-1:0]};
        c_low  = lo_seg[LOW_W];
        c_top  = hi_seg[HI_W];
        into_low_msb = x[LOW_W-1] ^ y[LOW_W-1] ^ sum[LOW_W-1];
        into_top_msb = x[XLEN-1] ^ y[XLEN-1] ^ sum[XLEN-1];
        sov_low = into_low_msb ^ c_low;
        sov_top = into_top_msb ^ c_top;
    end
endmodule

// File: rtl/xau_flags.sv
module xau_flags
    import xau_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LOW_W = 32
) (
    input  logic            valid,
    input  logic            known,
    input  logic            wr_res,
    input  logic            wr_ca,
    input  logic            ov_by_oe,
    input  logic            ov_is_carry,
    input  logic            is_cmp,
    input  logic            oe,
    input  logic            rc,
    input  logic            mode64,
    input  logic            so_in,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] sum,
    input  logic            c_low,
    input  logic            c_top,
    input  logic            sov_low,
    input  logic            sov_top,
    output xflags_t         fl
);
    logic act_carry, act_sov;
    logic res_neg, res_zero;
    logic cmp_lt, cmp_eq;
    logic ov_write, ov_val;

    always_comb begin
        act_carry = mode64 ? c_top : c_low;
        act_sov   = mode64 ? sov_top : sov_low;

        res_neg  = mode64 ? sum[XLEN-1] : sum[LOW_W-1];
        res_zero = mode64 ? (sum == '0) : (sum[LOW_W-1:0] == '0);

        cmp_lt = mode64 ? ($signed(a) < $signed(b))
                        : ($signed(a[LOW_W-1:0]) < $signed(b[LOW_W-1:0]));
        cmp_eq = mode64 ? (a == b) : (a[LOW_W-1:0] == b[LOW_W-1:0]);

        ov_write = valid & ((ov_by_oe & oe) | ov_is_carry);
        ov_val   = ov_is_carry ? act_carry : act_sov;

        fl         = '0;
        fl.res_we  = valid & wr_res;
        fl.ca_we   = valid & wr_ca;
        fl.ca32_we = valid & wr_ca;
        fl.ca      = act_carry;
        fl.ca32    = c_low;
        fl.ov_we   = ov_write;
        fl.ov32_we = ov_write;
        fl.ov      = ov_val;
        fl.ov32    = ov_is_carry ? c_low : sov_low;
        fl.so_we   = ov_write;
        fl.so      = so_in | (ov_write & ov_val);
        fl.cr0_we  = valid & known & (is_cmp | rc);
        fl.cr0     = is_cmp ? xau_cr_pack(cmp_lt, ~cmp_lt & ~cmp_eq, cmp_eq, so_in)
                            : xau_cr_pack(res_neg, ~res_neg & ~res_zero, res_zero, fl.so);
    end
endmodule

// File: rtl/xer_addsub_unit.sv
module xer_addsub_unit
    import xau_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LOW_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid_i,
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            so_i,
    input  logic            ca_i,
    input  logic            oe_i,
    input  logic            rc_i,
    input  logic            mode64_i,
    input  logic            cy_sel_i,
    output logic            out_valid_o,
    output logic [XLEN-1:0] result_o,
    output logic            res_we_o,
    output logic [3:0]      cr0_o,
    output logic            cr0_we_o,
    output logic            so_o,
    output logic            so_we_o,
    output logic [1:0]      ca_o,
    output logic            ca_we_o,
    output logic            ca32_we_o,
    output logic [1:0]      ov_o,
    output logic            ov_we_o,
    output logic            ov32_we_o
);
    xctl_t           ctl;
    logic [XLEN-1:0] opx, opy, sum;
    logic            cin, c_low, c_top, sov_low, sov_top;
    xflags_t         fl_d, fl_q;
    logic [XLEN-1:0] result_q;
    logic            valid_q;

    assign ctl = xau_decode(op_i, cy_sel_i);

    xau_operand #(.XLEN(XLEN)) u_operand (
        .inv_a   (ctl.inv_a),
        .zero_b  (ctl.zero_b),
        .cin_sel (ctl.cin_sel),
        .a       (a_i),
        .b       (b_i),
        .ca_in   (ca_i),
        .x       (opx),
        .y       (opy),
        .cin     (cin)
    );

    xau_adder #(.XLEN(XLEN), .LOW_W(LOW_W)) u_adder (
        .x       (opx),
        .y       (opy),
        .cin     (cin),
        .sum     (sum),
        .c_low   (c_low),
        .c_top   (c_top),
        .sov_low (sov_low),
        .sov_top (sov_top)
    );

    xau_flags #(.XLEN(XLEN), .LOW_W(LOW_W)) u_flags (
        .valid       (in_valid_i),
        .known       (ctl.known),
        .wr_res      (ctl.wr_res),
        .wr_ca       (ctl.wr_ca),
        .ov_by_oe    (ctl.ov_by_oe),
        .ov_is_carry (ctl.ov_is_carry),
        .is_cmp      (ctl.is_cmp),
        .oe          (oe_i),
        .rc          (rc_i),
        .mode64      (mode64_i),
        .so_in       (so_i),
        .a           (a_i),
        .b           (b_i),
        .sum         (sum),
        .c_low       (c_low),
        .c_top       (c_top),
        .sov_low     (sov_low),
        .sov_top     (sov_top),
        .fl          (fl_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            result_q <= '0;
            fl_q     <= '0;
        end else begin
            valid_q  <= in_valid_i;
            result_q <= sum;
            fl_q     <= fl_d;
        end
    end

    assign out_valid_o = valid_q;
    assign result_o    = result_q;
    assign res_we_o    = fl_q.res_we;
    assign cr0_o       = fl_q.cr0;
    assign cr0_we_o    = fl_q.cr0_we;
    assign so_o        = fl_q.so;
    assign so_we_o     = fl_q.so_we;
    assign ca_o        = {fl_q.ca, fl_q.ca32};
    assign ca_we_o     = fl_q.ca_we;
    assign ca32_we_o   = fl_q.ca32_we;
    assign ov_o        = {fl_q.ov, fl_q.ov32};
    assign ov_we_o     = fl_q.ov_we;
    assign ov32_we_o   = fl_q.ov32_we;

    AST_CMP_KEEPS_XER: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid_i && op_i == XOP_CMP) |-> !(so_we_o || ov_we_o || ca_we_o || res_we_o)); // R8
    AST_NOCARRY_KEEPS_CA: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid_i && (op_i == XOP_ADD || op_i == XOP_SUBF || op_i == XOP_NEG))
        |-> !(ca_we_o || ca32_we_o)); // R3
    AST_CA_PAIR: assert property (@(posedge clk) disable iff (rst)
        ca_we_o |-> ca32_we_o); // R2
    AST_OV_PAIR: assert property (@(posedge clk) disable iff (rst)
        ov_we_o |-> (ov32_we_o && so_we_o)); // R4
    AST_SO_FOLLOWS_OV: assert property (@(posedge clk) disable iff (rst)
        (so_we_o && ov_o[1]) |-> so_o); // R6
    AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid_i && so_i) && so_we_o) |-> so_o); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid_o |-> !(res_we_o || cr0_we_o || so_we_o || ca_we_o || ov_we_o)); // R10
    AST_CMP_SO_BIT: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid_i && op_i == XOP_CMP) |-> (cr0_we_o && cr0_o[0] == $past(so_i))); // R8

endmodule

// File: tb/xer_addsub_unit_bench.sv
`timescale 1ns/1ps
module xer_addsub_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [63:0] a_i = '0, b_i = '0;
    logic        so_i = 1'b0, ca_i = 1'b0, oe_i = 1'b0, rc_i = 1'b0;
    logic        mode64_i = 1'b1, cy_sel_i = 1'b0;
    logic        out_valid_o, res_we_o, cr0_we_o, so_o, so_we_o;
    logic        ca_we_o, ca32_we_o, ov_we_o, ov32_we_o;
    logic [63:0] result_o;
    logic [3:0]  cr0_o;
    logic [1:0]  ca_o, ov_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    xer_addsub_unit u_xer_addsub_unit (
        .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .so_i(so_i), .ca_i(ca_i), .oe_i(oe_i),
        .rc_i(rc_i), .mode64_i(mode64_i), .cy_sel_i(cy_sel_i),
        .out_valid_o(out_valid_o), .result_o(result_o), .res_we_o(res_we_o),
        .cr0_o(cr0_o), .cr0_we_o(cr0_we_o), .so_o(so_o), .so_we_o(so_we_o),
        .ca_o(ca_o), .ca_we_o(ca_we_o), .ca32_we_o(ca32_we_o),
        .ov_o(ov_o), .ov_we_o(ov_we_o), .ov32_we_o(ov32_we_o)
    );

    typedef struct packed {
        logic        vld;
        logic [63:0] res;
        logic        res_we;
        logic [3:0]  cr;
        logic        cr_we;
        logic        so;
        logic        so_we;
        logic [1:0]  ca;
        logic        ca_we;
        logic [1:0]  ov;
        logic        ov_we;
    } exp_t;

    function automatic exp_t model(input logic v, input logic [3:0] op,
                                   input logic [63:0] a, input logic [63:0] b,
                                   input logic so, input logic ca, input logic oe,
                                   input logic rc, input logic m64, input logic cy);
        exp_t e;
        logic [63:0] x, y, s;
        logic        cin, c64, c32, o64, o32, neg, zer, lt, eq, ovw, ovv;
        logic [64:0] full;
        logic [32:0] low;
        e = '0;
        x = a; y = b; cin = 1'b0;
        case (op)
            4'd2, 4'd8: cin = ca;
            4'd3, 4'd4: begin x = ~a; cin = 1'b1; end
            4'd5:       begin x = ~a; cin = ca; end
            4'd6:       begin x = ~a; y = '0; cin = 1'b1; end
            default: ;
        endcase
        full = {1'b0, x} + {1'b0, y} + 65'(cin);
        low  = {1'b0, x[31:0]} + {1'b0, y[31:0]} + 33'(cin);
        s    = full[63:0];
        c64  = full[64];
        c32  = low[32];
        o64  = (x[63] == y[63]) && (s[63] != x[63]);
        o32  = (x[31] == y[31]) && (s[31] != x[31]);
        e.vld = v;
        if (!v || op > 4'd8) return e;
        e.res = s;
        if (op == 4'd7) begin
            lt = m64 ? ($signed(a) < $signed(b)) : ($signed(a[31:0]) < $signed(b[31:0]));
            eq = m64 ? (a == b) : (a[31:0] == b[31:0]);
            e.cr = {lt, !lt && !eq, eq, so};
            e.cr_we = 1'b1;
            return e;
        end
        e.res_we = 1'b1;
        e.ca_we  = (op == 4'd1 || op == 4'd2 || op == 4'd4 || op == 4'd5 || op == 4'd8);
        e.ca     = {m64 ? c64 : c32, c32};
        if (op == 4'd8) begin
            ovw  = !cy;
            e.ov = {m64 ? c64 : c32, c32};
        end else begin
            ovw  = oe;
            e.ov = {m64 ? o64 : o32, o32};
        end
        ovv     = e.ov[1];
        e.ov_we = ovw;
        e.so_we = ovw;
        e.so    = so | (ovw & ovv);
        neg = m64 ? s[63] : s[31];
        zer = m64 ? (s == 64'd0) : (s[31:0] == 32'd0);
        e.cr    = {neg, !neg && !zer, zer, e.so};
        e.cr_we = rc;
        return e;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic run_op(input logic v, input logic [3:0] op,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic so, input logic ca, input logic oe,
                          input logic rc, input logic m64, input logic cy);
        exp_t  e;
        string ren, rca, rov, rcr, rres;
        in_valid_i = v; op_i = op; a_i = a; b_i = b; so_i = so; ca_i = ca;
        oe_i = oe; rc_i = rc; mode64_i = m64; cy_sel_i = cy;
        e = model(v, op, a, b, so, ca, oe, rc, m64, cy);
        @(posedge clk);
        @(negedge clk);
        ren  = (!v || op > 4'd8) ? "R10" : (op == 4'd7 ? "R8" : "R1");
        rca  = (op == 4'd0 || op == 4'd3 || op == 4'd6) ? "R3" : "R2";
        rov  = (op == 4'd8) ? "R5" : "R4";
        rcr  = (op == 4'd7) ? "R8" : "R7";
        rres = m64 ? "R1" : "R9";
        chk(ren, "out_valid", 64'(out_valid_o), 64'(e.vld));
        chk(ren, "res_we", 64'(res_we_o), 64'(e.res_we));
        chk(ren == "R1" ? rca : ren, "ca_we", 64'(ca_we_o), 64'(e.ca_we));
        chk(ren == "R1" ? rca : ren, "ca32_we", 64'(ca32_we_o), 64'(e.ca_we));
        chk(ren == "R1" ? rov : ren, "ov_we", 64'(ov_we_o), 64'(e.ov_we));
        chk(ren == "R1" ? rov : ren, "ov32_we", 64'(ov32_we_o), 64'(e.ov_we));
        chk(ren == "R1" ? "R6" : ren, "so_we", 64'(so_we_o), 64'(e.so_we));
        chk(ren == "R1" ? rcr : ren, "cr0_we", 64'(cr0_we_o), 64'(e.cr_we));
        if (e.res_we) chk(rres, "result", result_o, e.res);
        if (e.ca_we)  chk(m64 ? "R2" : "R9", "ca_pair", 64'(ca_o), 64'(e.ca));
        if (e.ov_we)  chk(m64 ? rov : "R9", "ov_pair", 64'(ov_o), 64'(e.ov));
        if (e.so_we)  chk("R6", "so", 64'(so_o), 64'(e.so));
        if (e.cr_we)  chk(m64 ? rcr : "R9", "cr0", 64'(cr0_o), 64'(e.cr));
    endtask

    function automatic logic [63:0] pick();
        case ($urandom_range(0, 9))
            0: return 64'd0;
            1: return '1;
            2: return 64'h7FFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h0000_0000_7FFF_FFFF;
            5: return 64'h0000_0000_8000_0000;
            6: return 64'h0000_0000_FFFF_FFFF;
            7: return 64'd1;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        rst = 1'b1;
        in_valid_i = 1'b1; op_i = 4'd1; oe_i = 1'b1; rc_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: enables cleared while in reset even with an operation presented
        chk("R11", "out_valid", 64'(out_valid_o), 64'd0);
        chk("R11", "enables", 64'({res_we_o, cr0_we_o, so_we_o, ca_we_o, ov_we_o}), 64'd0);
        rst = 1'b0;
        in_valid_i = 1'b0;

        // R4 signed overflow at 64 bits, none in the low slice
        run_op(1, 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 1, 1, 1, 0);
        // R9 32-bit mode overflow at bit 31
        run_op(1, 4'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 0, 0, 1, 1, 0, 0);
        // R2 carry out at both widths
        run_op(1, 4'd1, '1, 64'd1, 0, 0, 0, 1, 1, 0);
        // R9 carry at bit 31 only, upper bits kept
        run_op(1, 4'd1, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 0, 1, 0, 0);
        run_op(1, 4'd1, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 0, 1, 1, 0);
        // R1 subtract-from with borrow, R2 carry clear
        run_op(1, 4'd4, 64'd5, 64'd3, 0, 0, 0, 1, 1, 0);
        run_op(1, 4'd5, 64'd3, 64'd5, 0, 1, 1, 1, 1, 0);
        // R4 negate of most-negative value
        run_op(1, 4'd6, 64'h8000_0000_0000_0000, 64'd0, 0, 0, 1, 1, 1, 0);
        // R3 non-carrying operations
        run_op(1, 4'd3, 64'd1, 64'd0, 0, 1, 0, 0, 1, 0);
        // R8 compare in both modes
        run_op(1, 4'd7, '1, 64'd1, 1, 1, 1, 1, 1, 0);
        run_op(1, 4'd7, 64'h0000_0001_0000_0000, 64'd0, 0, 0, 1, 0, 0, 0);
        // R5 addex both carry-select values
        run_op(1, 4'd8, '1, 64'd0, 0, 1, 0, 1, 1, 0);
        run_op(1, 4'd8, '1, 64'd0, 0, 1, 1, 1, 1, 1);
        // R6 sticky SO with no new overflow
        run_op(1, 4'd0, 64'd2, 64'd3, 1, 0, 1, 1, 1, 0);
        // R10 unused code and idle slot
        run_op(1, 4'd12, 64'd4, 64'd4, 1, 1, 1, 1, 1, 0);
        run_op(0, 4'd1, 64'd4, 64'd4, 1, 1, 1, 1, 1, 0);

        for (int i = 0; i < 4000; i++) begin
            logic [3:0] op;
            op = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(9, 15))
                                              : 4'($urandom_range(0, 8));
            run_op($urandom_range(0, 15) != 0, op, pick(), pick(),
                   1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule